// File: doc/BRIEF.md
# Test Access Port Controller with Bypass and Identification Registers

This block is the device side of a four-wire serial test port. A test clock, a mode-select line and a serial data input steer a sixteen-state controller; the controller in turn decides when the serial input is routed through a 4-bit instruction register or through one of two data registers, and when the serial output is driven. The data registers are a single-bit pass-through register and a 32-bit identification register holding a fixed device number.

A host scans an instruction in, then scans data through the register that instruction picks. The all-ones instruction and every instruction the block does not recognise pick the one-bit path, which makes a string of such devices look like a chain of flip-flops that the host can count. The identification opcode is a parameter. After any reset the identification register is selected, so the device number can be read with no instruction scan at all.

Top module: `jtag_tap`

## Requirements
- R1: Driving trst_n low forces the reset state at once, without a clock: tdo_oe and tdo go low straight away, and the identification instruction is current once trst_n is released.
- R2: Five consecutive rising test-clock edges with tms high bring the controller to its reset state from any state, which makes the identification instruction current again.
- R3: tdo and tdo_oe change on the falling test-clock edge; tdo_oe is high only while the controller is in the instruction-shift or data-shift state, and tdo is 0 whenever tdo_oe is low.
- R4: On the capture step of an instruction scan the instruction shift register loads 4'b0001, whatever instruction is current; it then shifts out and in least significant bit first.
- R5: The instruction 4'b1111 selects the one-bit path: capture loads 0 and each tdi bit reaches tdo exactly one shift later.
- R6: The instruction equal to parameter ID_OP selects the 32-bit register: capture loads ID_VAL (whose bit 0 is 1), shifted out bit 0 first, after which the tdi bits follow 32 shifts later.
- R7: Every instruction other than ID_OP behaves as the one-bit path, including the capture value 4'b0001 when ID_OP differs from it.
- R8: The current instruction changes only on leaving the instruction-update state (or in reset); a pause in the instruction scan keeps the partly shifted value, and scanning resumes where it stopped.
- R9: A pause in a data scan keeps the data register contents, so a 32-bit read split by a pause returns the same bits in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on the rising test-clock edge |
| tdi | input | 1 | Serial data in, sampled on the rising test-clock edge |
| tdo | output | 1 | Serial data out, updated on the falling test-clock edge |
| tdo_oe | output | 1 | Output enable for tdo, high only in the two shift states |

## Verification
The bench builds the block with ID_OP set to 4'b0010 rather than the default and an identification value of 32'h1A5C_3E2B. Because the instruction capture value 4'b0001 then differs from the identification opcode, an instruction scan that merely passes capture and update lands on an unrecognised code, which brings the fallback-to-bypass rule within reach; a value with mixed bits across all nibbles exposes any bit-order or off-by-one error in the 32-bit read.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_DR_SCAN,
        ST_DR_CAPTURE,
        ST_DR_SHIFT,
        ST_DR_EXIT1,
        ST_DR_PAUSE,
        ST_DR_EXIT2,
        ST_DR_UPDATE,
        ST_IR_SCAN,
        ST_IR_CAPTURE,
        ST_IR_SHIFT,
        ST_IR_EXIT1,
        ST_IR_PAUSE,
        ST_IR_EXIT2,
        ST_IR_UPDATE
    } tap_state_e;

    typedef enum logic {
        SEL_BYPASS,
        SEL_IDENT
    } dr_sel_e;

    typedef struct packed {
        logic oe;
        logic dat;
    } tdo_out_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            ST_RESET:      n = tms ? ST_RESET     : ST_IDLE;
            ST_IDLE:       n = tms ? ST_DR_SCAN   : ST_IDLE;
            ST_DR_SCAN:    n = tms ? ST_IR_SCAN   : ST_DR_CAPTURE;
            ST_DR_CAPTURE: n = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_SHIFT:   n = tms ? ST_DR_EXIT1  : ST_DR_SHIFT;
            ST_DR_EXIT1:   n = tms ? ST_DR_UPDATE : ST_DR_PAUSE;
            ST_DR_PAUSE:   n = tms ? ST_DR_EXIT2  : ST_DR_PAUSE;
            ST_DR_EXIT2:   n = tms ? ST_DR_UPDATE : ST_DR_SHIFT;
            ST_DR_UPDATE:  n = tms ? ST_DR_SCAN   : ST_IDLE;
            ST_IR_SCAN:    n = tms ? ST_RESET     : ST_IR_CAPTURE;
            ST_IR_CAPTURE: n = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_SHIFT:   n = tms ? ST_IR_EXIT1  : ST_IR_SHIFT;
            ST_IR_EXIT1:   n = tms ? ST_IR_UPDATE : ST_IR_PAUSE;
            ST_IR_PAUSE:   n = tms ? ST_IR_EXIT2  : ST_IR_PAUSE;
            ST_IR_EXIT2:   n = tms ? ST_IR_UPDATE : ST_IR_SHIFT;
            default:       n = tms ? ST_DR_SCAN   : ST_IDLE;
        endcase
        return n;
    endfunction

    // Only the identification opcode is decoded; everything else is the one-bit path.
    function automatic dr_sel_e ir_decode(logic [3:0] ir, logic [3:0] id_op);
        return (ir == id_op) ? SEL_IDENT : SEL_BYPASS;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= tap_next(state, tms);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int          IR_W  = 4,
    parameter logic [3:0]  ID_OP = 4'b0001
) (
    input  logic            tck,
    input  logic            trst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] ir,
    output logic [IR_W-1:0] ir_shift
);
    localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-2){1'b0}}, 2'b01};
    localparam logic [IR_W-1:0] ID_VAL  = IR_W'(ID_OP);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir_shift <= CAP_VAL;
        end else begin
            case (state)
                ST_IR_CAPTURE: ir_shift <= CAP_VAL;
                ST_IR_SHIFT:   ir_shift <= {tdi, ir_shift[IR_W-1:1]};
                default:       ir_shift <= ir_shift;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir <= ID_VAL;
        end else begin
            case (state)
                ST_RESET:     ir <= ID_VAL;
                ST_IR_UPDATE: ir <= ir_shift;
                default:      ir <= ir;
            endcase
        end
    end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W   = 32,
    parameter logic [ID_W-1:0] ID_VAL = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    input  dr_sel_e    sel,
    output logic       dr_lsb
);
    logic            byp_q;
    logic [ID_W-1:0] id_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (sel == SEL_BYPASS) begin
            case (state)
                ST_DR_CAPTURE: byp_q <= 1'b0;
                ST_DR_SHIFT:   byp_q <= tdi;
                default:       byp_q <= byp_q;
            endcase
        end
    end

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            id_q <= '0;
        end else if (sel == SEL_IDENT) begin
            case (state)
                ST_DR_CAPTURE: id_q <= ID_VAL;
                ST_DR_SHIFT:   id_q <= {tdi, id_q[ID_W-1:1]};
                default:       id_q <= id_q;
            endcase
        end
    end

    assign dr_lsb = (sel == SEL_IDENT) ? id_q[0] : byp_q;
endmodule

// File: rtl/jtag_tap.sv
module jtag_tap
    import jtag_tap_pkg::*;
#(
    parameter int          IR_W   = 4,
    parameter int          ID_W   = 32,
    parameter logic [3:0]  ID_OP  = 4'b0001,
    parameter logic [31:0] ID_VAL = 32'h0000_0001
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe
);
    tap_state_e      state;
    logic [IR_W-1:0] ir;
    logic [IR_W-1:0] ir_shift;
    dr_sel_e         dr_sel;
    logic            dr_lsb;
    tdo_out_t        out_d, out_q;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir #(.IR_W(IR_W), .ID_OP(ID_OP)) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .tdi      (tdi),
        .ir       (ir),
        .ir_shift (ir_shift)
    );

    assign dr_sel = ir_decode(4'(ir), ID_OP);

    tap_dr #(.ID_W(ID_W), .ID_VAL(ID_W'(ID_VAL))) u_dr (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .sel    (dr_sel),
        .dr_lsb (dr_lsb)
    );

    always_comb begin
        out_d = '0;
        case (state)
            ST_IR_SHIFT: out_d = '{oe: 1'b1, dat: ir_shift[0]};
            ST_DR_SHIFT: out_d = '{oe: 1'b1, dat: dr_lsb};
            default:     out_d = '0;
        endcase
    end

    // Output stage retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) out_q <= '0;
        else         out_q <= out_d;
    end

    assign tdo    = out_q.dat;
    assign tdo_oe = out_q.oe;
endmodule

// File: rtl/jtag_tap_chk.sv
module jtag_tap_chk
    import jtag_tap_pkg::*;
#(
    parameter int         IR_W  = 4,
    parameter logic [3:0] ID_OP = 4'b0001
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tms,
    input logic            tdo,
    input logic            tdo_oe,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir,
    input logic [IR_W-1:0] ir_shift
);
    localparam logic [IR_W-1:0] CAP_VAL = {{(IR_W-2){1'b0}}, 2'b01};

    logic [2:0] ones_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)          ones_q <= 3'd0;
        else if (!tms)        ones_q <= 3'd0;
        else if (ones_q != 7) ones_q <= ones_q + 3'd1;
    end

    // R2: five TMS-high edges land in reset
    a_r2_five_ones: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_q >= 3'd5) |-> (state == ST_RESET));

    // R1: reset state makes identification current
    a_r1_reset_ident: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_RESET) |=> (ir == IR_W'(ID_OP)));

    // R3: enable only in shift states
    a_r3_oe_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

    // R3: output low when not enabled
    a_r3_tdo_quiet: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

    // R4: capture loads the fixed pattern
    a_r4_ir_capture: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IR_CAPTURE) |=> (ir_shift == CAP_VAL));

    // R8: instruction only moves on update or reset
    a_r8_ir_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_IR_UPDATE && state != ST_RESET) |=> $stable(ir));
endmodule

bind jtag_tap jtag_tap_chk #(.IR_W(IR_W), .ID_OP(ID_OP)) u_chk (
    .tck      (tck),
    .trst_n   (trst_n),
    .tms      (tms),
    .tdo      (tdo),
    .tdo_oe   (tdo_oe),
    .state    (state),
    .ir       (ir),
    .ir_shift (ir_shift)
);

// File: tb/jtag_tap_test.sv
module jtag_tap_test;
    localparam logic [3:0]  B_ID_OP  = 4'b0010;
    localparam logic [31:0] B_ID_VAL = 32'h1A5C_3E2B;
    localparam int          B_IR_W   = 4;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  bv;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 tck = ~tck;

    jtag_tap #(.IR_W(B_IR_W), .ID_W(32), .ID_OP(B_ID_OP), .ID_VAL(B_ID_VAL)) uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected bit for each enabled output slot.
    initial begin
        forever begin
            @(negedge tck);
            #2;
            if (tdo_oe) begin
                if (q.size() == 0) begin
                    check(1'b0, "R3 unexpected shift slot", 64'(tdo), 64'hx);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(tdo === e.bv, e.tag, 64'(tdo), 64'(e.bv));
                end
            end else begin
                check(tdo === 1'b0, "R3 idle tdo", 64'(tdo), 64'd0);
            end
        end
    end

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
    endtask

    task automatic drain(input string tag);
        @(negedge tck);
        @(negedge tck);
        #3;
        check(q.size() == 0, tag, 64'(q.size()), 64'd0);
    endtask

    // Scan from idle back to idle; pushes expected output then drives tms/tdi.
    task automatic scan(input bit is_ir, input int n, input logic [63:0] data,
                        input int len, input logic [63:0] cap, input int pause_at,
                        input string tag);
        for (int k = 0; k < n; k++) begin
            exp_t e;
            e.tag = tag;
            e.bv  = (k < len) ? cap[k] : data[k - len];
            q.push_back(e);
        end
        tick(1, 0);
        if (is_ir) tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        for (int i = 0; i < n; i++) begin
            bit last = (i == n - 1);
            bit brk  = (pause_at > 0) && (i == pause_at - 1) && !last;
            tick(last || brk, data[i]);
            if (brk) begin
                tick(0, 0);
                tick(0, 0);
                tick(0, 0);
                tick(1, 0);
                tick(0, 0);
            end
        end
        tick(1, 0);
        tick(0, 0);
        drain({tag, " drain"});
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        done = 1;
    end

    initial begin
        // R1: reset state at the ports
        #10;
        check(tdo_oe === 1'b0 && tdo === 1'b0, "R1 reset outputs", {62'd0, tdo_oe, tdo}, 64'd0);
        #10;
        trst_n = 1'b1;
        tick(0, 0);

        // R6: identification read straight after reset, then tdi emerges after 32 shifts
        scan(0, 40, {24'd0, 40'hA5_0000_0000}, 32, 64'(B_ID_VAL), 0, "R6 ident read");

        // R4: capture pattern 0001 shifted out lsb first, load all-ones
        scan(1, 4, 64'hF, 4, 64'h1, 0, "R4 ir capture");

        // R5: all-ones selects the one-bit path
        scan(0, 16, 64'hC3A5, 1, 64'h0, 0, "R5 bypass delay");

        // R4: capture value is fixed regardless of current instruction
        scan(1, 4, 64'(B_ID_OP), 4, 64'h1, 0, "R4 ir capture again");

        // R9: identification read split by a pause
        scan(0, 32, 64'h0, 32, 64'(B_ID_VAL), 13, "R9 paused ident");

        // R8: paused instruction scan loading the capture value 0001
        scan(1, 4, 64'h1, 4, 64'h1, 2, "R8 paused ir");

        // R7: 0001 is not the identification opcode here, so one-bit path
        scan(0, 10, 64'h2D3, 1, 64'h0, 0, "R7 fallback bypass");

        // R2: load bypass, start an instruction scan, leave with five tms-high edges
        scan(1, 4, 64'hF, 4, 64'h1, 0, "R2 ir setup");
        begin
            exp_t e;
            e.tag = "R2 partial capture";
            e.bv = 1'b1; q.push_back(e);
            e.bv = 1'b0; q.push_back(e);
        end
        tick(1, 0);
        tick(1, 0);
        tick(0, 0);
        tick(0, 1);
        tick(0, 1);
        tick(1, 1);
        tick(1, 0);
        tick(1, 0);
        tick(1, 0);
        tick(1, 0);
        tick(0, 0);
        drain("R2 partial drain");
        scan(0, 32, 64'h0, 32, 64'(B_ID_VAL), 0, "R2 ident after reset");

        // R1: asynchronous reset in the middle of a bypass data shift
        scan(1, 4, 64'hF, 4, 64'h1, 0, "R1 ir setup");
        begin
            exp_t e;
            e.tag = "R1 bypass capture";
            e.bv = 1'b0;
            q.push_back(e);
        end
        tick(1, 0);
        tick(0, 0);
        tick(0, 0);
        @(posedge tck);
        @(negedge tck);
        #3;
        check(tdo_oe === 1'b1, "R1 shifting before reset", 64'(tdo_oe), 64'd1);
        trst_n = 1'b0;
        #1;
        check(tdo_oe === 1'b0 && tdo === 1'b0, "R1 async reset outputs", {62'd0, tdo_oe, tdo}, 64'd0);
        #1;
        trst_n = 1'b1;
        tick(0, 0);
        drain("R1 drain");
        scan(0, 32, 64'h0, 32, 64'(B_ID_VAL), 0, "R1 ident after trst");

        done = 1;
    end

    initial begin
        wait (done);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule